// File: doc/BRIEF.md
# Device ID Gate Controller

This block reads a fixed, factory-set identifier from a serial ID port and uses it to open or hold shut a gate signal for the rest of the chip. After a start request it issues a one-cycle load strobe to the port. It then holds the port's shift enable for one cycle per identifier bit and collects the serial output into a parallel register, first bit received in the most significant place. When the capture is complete, the collected value is compared with a parameterised expected identifier. A design-enable output is raised only if the two agree.

An optional verify run can be selected at start time. In that run the serial input of the port is fed from its own serial output, so the identifier circulates back into the port. The controller then shifts a second full pass and compares it bit by bit with the first. Any difference is reported as a rollover error and blocks the match. In a normal run the serial input of the port is held low.

The state sequence is idle, load (one cycle), shift (one cycle per bit), an optional verify pass of the same length, check, and done.

Top module: `idgate_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, `done_o`, `match_o`, `enable_o`, `roll_err_o`, `id_load_o` and `id_shift_o` are 0 and `id_value_o` is all zeros.
- R2: Each accepted run drives `id_load_o` high for exactly one clock cycle, beginning the cycle after the accepting edge, with `id_shift_o` low in that cycle.
- R3: `id_shift_o` is high for exactly ID_W consecutive cycles immediately after the load cycle (2*ID_W in a verify run). The bit sampled from `id_dout_i` in the first shift cycle lands in bit ID_W-1 of `id_value_o`, and the last one lands in bit 0.
- R4: Counting the edge that accepts the start as edge 1, `done_o` is high after edge ID_W+3 in a normal run and after edge 2*ID_W+3 in a verify run (60 and 117 for ID_W = 57).
- R5: In a normal run `id_din_o` is 0 in every shift cycle. In a verify run `id_din_o` equals `id_dout_i` in every shift cycle.
- R6: A start request is ignored unless the controller is idle. A pulse mid-run does not change the run's timing or result.
- R7: `match_o` is registered and changes only on the edge that leaves the check state. It becomes 1 exactly when `id_value_o` equals EXP_ID and no rollover error was seen. Otherwise it becomes 0. Between checks it keeps its last value.
- R8: `enable_o` is high only when the latest check confirmed a match. It is cleared on the edge that accepts a new start.
- R9: In a verify run, any second-pass bit that differs from the first-pass bit in the same position sets `roll_err_o` to 1 and forces `match_o` and `enable_o` to 0. `roll_err_o` is cleared when a new start is accepted.
- R10: `done_o` is set on completion of the check and stays high until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only when idle |
| roll_chk_i | input | 1 | Selects a verify run (rollover + second pass), sampled with the start |
| id_load_o | output | 1 | Load strobe to the ID port |
| id_shift_o | output | 1 | Shift enable to the ID port |
| id_din_o | output | 1 | Serial data into the far end of the ID port chain |
| id_dout_i | input | 1 | Serial data out of the ID port |
| id_value_o | output | ID_W | Captured identifier, first received bit in the MSB |
| done_o | output | 1 | Run complete |
| match_o | output | 1 | Captured identifier equals EXP_ID with no rollover error |
| enable_o | output | 1 | Design enable, high only after a confirmed match |
| roll_err_o | output | 1 | Second pass differed from the first |

## Verification
A bit counter that is off by one shows up at the ports on the same run. The `id_shift_o` pulse is one cycle too long or too short, `done_o` lands one edge early or late, and the captured value is shifted by one place against the port's contents. As a result, the match with EXP_ID fails at the check, about sixty cycles after the start. A state register that escapes idle on a mid-run start shows as a second load strobe and a wrong completion time in that same run. A verify comparator that indexes the wrong bit raises `roll_err_o` on a clean circulating identifier at the end of the second pass.

// File: rtl/idgate_pkg.sv
package idgate_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOAD   = 3'd1,
      ST_SHIFT  = 3'd2,
      ST_VERIFY = 3'd3,
      ST_CHECK  = 3'd4,
      ST_DONE   = 3'd5
   } idg_state_e;

   function automatic logic is_shifting(input idg_state_e s);
      return (s == ST_SHIFT) || (s == ST_VERIFY);
   endfunction

endpackage

// File: rtl/idgate_seq.sv
module idgate_seq
   import idgate_pkg::*;
#(
   parameter int ID_W      = 57,
   parameter bit VERIFY_EN = 1'b1,
   localparam int CNT_W    = $clog2(ID_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             roll_i,
   output idg_state_e       st_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             accept_o,
   output logic             roll_q_o
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ID_W - 1);

   idg_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic             roll_q;
   logic             last_bit;

   assign accept_o = (st_q == ST_IDLE) && start_i;
   assign last_bit = (cnt_q == LAST_IDX);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (start_i) st_d = ST_LOAD;
         ST_LOAD:   st_d = ST_SHIFT;
         ST_SHIFT:  if (last_bit) st_d = roll_q ? ST_VERIFY : ST_CHECK;
         ST_VERIFY: if (last_bit) st_d = ST_CHECK;
         ST_CHECK:  st_d = ST_DONE;
         ST_DONE:   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (is_shifting(st_q) && !last_bit) cnt_q <= cnt_q + 1'b1;
         else                                cnt_q <= '0;
      end
   end

   generate
      if (VERIFY_EN) begin : g_roll
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        roll_q <= 1'b0;
            else if (accept_o) roll_q <= roll_i;
         end
      end else begin : g_noroll
         assign roll_q = 1'b0;
      end
   endgenerate

   assign st_o     = st_q;
   assign cnt_o    = cnt_q;
   assign roll_q_o = roll_q;

endmodule

// File: rtl/idgate_capture.sv
module idgate_capture
   import idgate_pkg::*;
#(
   parameter int ID_W      = 57,
   parameter bit VERIFY_EN = 1'b1,
   localparam int CNT_W    = $clog2(ID_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  idg_state_e       st_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             bit_i,
   output logic [ID_W-1:0]  cap_o,
   output logic             err_o
);

   localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(ID_W - 1);

   logic [ID_W-1:0] cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cap_q <= '0;
      else if (st_i == ST_SHIFT) cap_q <= {cap_q[ID_W-2:0], bit_i};
   end

   generate
      if (VERIFY_EN) begin : g_verify
         logic             err_q;
         logic [CNT_W-1:0] ref_idx;
         logic             diff;

         assign ref_idx = TOP_IDX - cnt_i;
         assign diff    = (st_i == ST_VERIFY) && (bit_i != cap_q[ref_idx]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        err_q <= 1'b0;
            else if (accept_i) err_q <= 1'b0;
            else if (diff)     err_q <= 1'b1;
         end
         assign err_o = err_q;
      end else begin : g_noverify
         assign err_o = 1'b0;
      end
   endgenerate

   assign cap_o = cap_q;

endmodule

// File: rtl/idgate_judge.sv
module idgate_judge
   import idgate_pkg::*;
#(
   parameter int              ID_W   = 57,
   parameter logic [ID_W-1:0] EXP_ID = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            accept_i,
   input  idg_state_e      st_i,
   input  logic [ID_W-1:0] cap_i,
   input  logic            err_i,
   output logic            match_o,
   output logic            enable_o,
   output logic            done_o
);

   logic hit;
   logic match_q, enable_q, done_q;

   assign hit = (cap_i == EXP_ID) && !err_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q  <= 1'b0;
         enable_q <= 1'b0;
         done_q   <= 1'b0;
      end else if (accept_i) begin
         enable_q <= 1'b0;
         done_q   <= 1'b0;
      end else if (st_i == ST_CHECK) begin
         match_q  <= hit;
         enable_q <= hit;
         done_q   <= 1'b1;
      end
   end

   assign match_o  = match_q;
   assign enable_o = enable_q;
   assign done_o   = done_q;

endmodule

// File: rtl/idgate_ctrl.sv
module idgate_ctrl
   import idgate_pkg::*;
#(
   parameter int              ID_W      = 57,
   parameter logic [ID_W-1:0] EXP_ID    = 57'h1B3C5D7E9F02468,
   parameter bit              VERIFY_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            roll_chk_i,
   output logic            id_load_o,
   output logic            id_shift_o,
   output logic            id_din_o,
   input  logic            id_dout_i,
   output logic [ID_W-1:0] id_value_o,
   output logic            done_o,
   output logic            match_o,
   output logic            enable_o,
   output logic            roll_err_o
);

   localparam int CNT_W = $clog2(ID_W);

   generate
      if (ID_W < 2) begin : g_bad_width
         $error("idgate_ctrl: ID_W must be at least 2");
      end
   endgenerate

   idg_state_e       st;
   logic [CNT_W-1:0] cnt;
   logic             accept;
   logic             roll_q;
   logic             err;

   idgate_seq #(.ID_W(ID_W), .VERIFY_EN(VERIFY_EN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .roll_i   (roll_chk_i),
      .st_o     (st),
      .cnt_o    (cnt),
      .accept_o (accept),
      .roll_q_o (roll_q)
   );

   idgate_capture #(.ID_W(ID_W), .VERIFY_EN(VERIFY_EN)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .st_i     (st),
      .cnt_i    (cnt),
      .bit_i    (id_dout_i),
      .cap_o    (id_value_o),
      .err_o    (err)
   );

   idgate_judge #(.ID_W(ID_W), .EXP_ID(EXP_ID)) u_judge (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .st_i     (st),
      .cap_i    (id_value_o),
      .err_i    (err),
      .match_o  (match_o),
      .enable_o (enable_o),
      .done_o   (done_o)
   );

   assign id_load_o  = (st == ST_LOAD);
   assign id_shift_o = is_shifting(st);
   assign id_din_o   = roll_q && is_shifting(st) && id_dout_i;
   assign roll_err_o = err;

endmodule

// File: rtl/idgate_chk.sv
module idgate_chk
   import idgate_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input idg_state_e st,
   input logic       roll_q,
   input logic       id_load_o,
   input logic       id_shift_o,
   input logic       id_din_o,
   input logic       done_o,
   input logic       match_o,
   input logic       enable_o,
   input logic       roll_err_o
);

   // R2: load strobe lasts a single cycle and never overlaps a shift
   a_r2_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      id_load_o |=> !id_load_o);
   a_r2_load_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
      id_load_o |-> !id_shift_o);

   // R3: shifting always begins right after a load
   a_r3_shift_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_shift_o) |-> $past(id_load_o));

   // R5: serial input stays low outside a verify run
   a_r5_din_low: assert property (@(posedge clk) disable iff (!rst_n)
      !roll_q |-> !id_din_o);

   // R6: a start outside idle never produces a load
   a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && st != ST_IDLE && st != ST_DONE) |=> !id_load_o);

   // R7: match changes only when leaving the check state
   a_r7_match_only_check: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(match_o) |-> $past(st == ST_CHECK));

   // R8: enable implies a confirmed match
   a_r8_enable_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      enable_o |-> match_o);

   // R9: a rollover error rules out the enable
   a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (roll_err_o && done_o) |-> !enable_o);

   // R10: done rises only out of the check state
   a_r10_done_from_check: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(st == ST_CHECK));

endmodule

bind idgate_ctrl idgate_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .st         (st),
   .roll_q     (roll_q),
   .id_load_o  (id_load_o),
   .id_shift_o (id_shift_o),
   .id_din_o   (id_din_o),
   .done_o     (done_o),
   .match_o    (match_o),
   .enable_o   (enable_o),
   .roll_err_o (roll_err_o)
);

// File: tb/sim_idport.sv
module sim_idport #(
   parameter int              W      = 57,
   parameter logic [W-1:0]    SIM_ID = '0
) (
   input  logic         clk,
   input  logic         load,
   input  logic         shift,
   input  logic         din,
   output logic         dout,
   input  logic         use_alt,
   input  logic [W-1:0] alt_val
);

   logic [W-1:0] sr = '0;

   always_ff @(posedge clk) begin
      if (load)       sr <= use_alt ? alt_val : SIM_ID;
      else if (shift) sr <= {sr[W-2:0], din};
   end

   assign dout = sr[W-1];

endmodule

// File: tb/sim_idgate_ctrl.sv
`timescale 1ns/1ps
module sim_idgate_ctrl;

   localparam int              W   = 57;
   localparam logic [W-1:0]    EXP = 57'h1B3C5D7E9F02468;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         roll = 1'b0;
   logic         load, shift, ctl_din, port_din, dout;
   logic [W-1:0] idv;
   logic         done, match, enable, rerr;
   logic         use_alt = 1'b0;
   logic [W-1:0] alt_val = '0;
   logic         corrupt = 1'b0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   idgate_ctrl #(.ID_W(W), .EXP_ID(EXP)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .roll_chk_i(roll),
      .id_load_o(load), .id_shift_o(shift), .id_din_o(ctl_din),
      .id_dout_i(dout), .id_value_o(idv), .done_o(done),
      .match_o(match), .enable_o(enable), .roll_err_o(rerr)
   );

   assign port_din = ctl_din ^ corrupt;

   sim_idport #(.W(W)) u_port (
      .clk(clk), .load(load), .shift(shift), .din(port_din), .dout(dout),
      .use_alt(use_alt), .alt_val(alt_val)
   );

   typedef struct {
      logic [W-1:0] id;
      bit           m;
      bit           e;
      bit           rl;
      int           lat;
      int           nsh;
      int           t0;
   } item_t;

   item_t q[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: counts port activity and scores each completed run
   int  n_load = 0, n_shift = 0, n_dinbad = 0;
   bit  done_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (load)  n_load++;
         if (shift) n_shift++;
         if (shift && q.size() != 0) begin
            if (q[0].rl ? (ctl_din != dout) : (ctl_din != 1'b0)) n_dinbad++;
         end
         if (shift && load) n_dinbad += 1000;
         if (done && !done_prev && q.size() != 0) begin
            item_t it;
            it = q.pop_front();
            chk(idv == it.id, "R3 captured id", 64'(idv), 64'(it.id));
            chk(match == it.m, "R7 match", 64'(match), 64'(it.m));
            chk(enable == it.m, "R8 enable", 64'(enable), 64'(it.m));
            chk(rerr == it.e, "R9 rollover error", 64'(rerr), 64'(it.e));
            chk((cyc - it.t0 + 1) == it.lat, "R4 latency",
                64'(cyc - it.t0 + 1), 64'(it.lat));
            chk(n_load == 1, "R2 load cycles", 64'(n_load), 64'd1);
            chk(n_shift == it.nsh, "R3 shift cycles", 64'(n_shift), 64'(it.nsh));
            chk(n_dinbad == 0, "R5 serial input", 64'(n_dinbad), 64'd0);
            n_load = 0; n_shift = 0; n_dinbad = 0;
         end
         done_prev = done;
      end
   end

   // driver: pushes the expected result and starts one run
   task automatic run(input bit alt, input logic [W-1:0] v, input bit rl,
                      input bit corr, input bit extra, input bit hold);
      item_t it;
      bit    prev_m;
      @(negedge clk);
      use_alt = alt; alt_val = v; roll = rl; corrupt = corr;
      it.id  = alt ? v : '0;
      it.e   = rl && corr;
      it.m   = (it.id == EXP) && !it.e;
      it.rl  = rl;
      it.lat = rl ? 2*W + 3 : W + 3;
      it.nsh = rl ? 2*W : W;
      it.t0  = cyc + 1;
      prev_m = match;
      q.push_back(it);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (hold) begin
         repeat (6) @(negedge clk);
         chk(match == prev_m, "R7 match held mid-run", 64'(match), 64'(prev_m));
         chk(enable == 1'b0, "R8 enable cleared on start", 64'(enable), 64'd0);
         chk(done == 1'b0, "R10 done cleared on start", 64'(done), 64'd0);
      end
      if (extra) begin
         repeat (20) @(negedge clk);
         start = 1'b1;   // R6: must be ignored
         @(negedge clk);
         start = 1'b0;
      end
      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(done == 1'b1, "R10 done holds", 64'(done), 64'd1);
      chk(load == 1'b0 && shift == 1'b0, "R6 no rerun after ignored start",
          64'({load, shift}), 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({done, match, enable, rerr, load, shift} == 6'b0, "R1 outputs in reset",
          64'({done, match, enable, rerr, load, shift}), 64'd0);
      chk(idv == '0, "R1 id in reset", 64'(idv), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({done, match, enable, rerr} == 4'b0, "R1 outputs after reset",
          64'({done, match, enable, rerr}), 64'd0);

      run(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);                      // default zero ID
      run(1'b1, EXP, 1'b0, 1'b0, 1'b0, 1'b0);                     // match
      run(1'b1, EXP ^ 57'd1, 1'b0, 1'b0, 1'b0, 1'b1);             // LSB wrong, R7/R8 hold
      run(1'b1, EXP, 1'b0, 1'b0, 1'b1, 1'b0);                     // R6 mid-run start
      run(1'b1, EXP ^ (57'd1 << (W-1)), 1'b0, 1'b0, 1'b0, 1'b0);  // MSB wrong
      run(1'b1, EXP, 1'b1, 1'b0, 1'b0, 1'b0);                     // R9 clean verify
      run(1'b1, EXP, 1'b1, 1'b1, 1'b0, 1'b0);                     // R9 corrupted second pass
      run(1'b1, EXP, 1'b0, 1'b0, 1'b0, 1'b0);                     // R9 error cleared
      run(1'b1, 57'h0AAAAAAAAAAAAAA, 1'b1, 1'b0, 1'b1, 1'b1);     // verify, wrong id

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule